// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for each beat of a four-beat burst on a synchronous burst memory. When the load strobe is accepted at a rising clock edge, the start address is registered. The upper bits are then held for the rest of the burst, and the two low bits seed a small beat counter. On each later edge where the advance strobe is active, the low bits step to the next position of the burst. The address never leaves the aligned four-word block.

Two orders are offered, and a static mode input picks one. Linear order counts up by one modulo four. Interleaved order XORs the captured low bits with a beat count that runs 0, 1, 2, 3. A board that leaves the mode input unconnected is expected to pull it high, which gives interleaved order. The output is the full current address. It is driven straight from registers through a small combinational map, so it is valid in the cycle after the edge that changed it.

Top module: `burst_seq_gen`

## Requirements
- R1: While the synchronous active-low reset is low at a rising edge, the address register and beat counter clear, so the output reads all zeros from the next cycle, and a load strobe in that cycle is not honoured.
- R2: A rising edge with `load_n` low makes the output equal to the whole `start_addr` from the following cycle.
- R3: The upper address bits (all but the two lowest) change only at an edge that accepts a load; advancing never alters them.
- R4: With `mode` low (linear), each advance edge sets the low two bits to their previous value plus one, modulo 4 (start 1 gives 1, 2, 3, 0).
- R5: Stepping from low bits 3 in linear order gives 0 and produces no carry into the upper bits, even when every upper bit is 1.
- R6: With `mode` high (interleaved), the low two bits equal the captured start bits XOR a beat count that resets to 0 on load and rises by one per advance (start 1 gives 1, 0, 3, 2; start 3 gives 3, 2, 1, 0).
- R7: An edge with both `load_n` and `adv_n` high leaves the output unchanged, whatever `start_addr` carries.
- R8: When `load_n` and `adv_n` are both low at the same edge, the load wins: the output becomes `start_addr` and the beat count restarts at 0.
- R9: In either order, four advances after a load bring the address back to the start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_n | input | 1 | Address load strobe, active low |
| adv_n | input | 1 | Burst advance strobe, active low |
| mode | input | 1 | Burst order: 0 linear, 1 interleaved (hold high when unused) |
| start_addr | input | ADDR_W (18) | Start address captured on load |
| word_addr | output | ADDR_W (18) | Current burst word address |

## Verification
Loading a new start address and advancing the current burst can both be requested at the same edge. The bench provokes this in the middle of an interleaved burst by driving `load_n` and `adv_n` low together with a start address whose low bits differ from the current beat. It judges the result by requiring that the output equals the new start address exactly, and that the next advance steps from a beat count of zero rather than from the old one.

// File: rtl/burst_pkg.sv
// Package: shared types for the burst address sequence generator.
// Assumes: nothing beyond IEEE 1800-2017.
package burst_pkg;
    // Burst order selected by the static mode input.
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;
endpackage

// File: rtl/burst_upper_reg.sv
// Module: burst_upper_reg
// Holds the address bits that stay fixed for the duration of a burst.
// Assumes: load_en is already qualified; reset is synchronous, active low.
module burst_upper_reg #(
    parameter int HI_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_en,
    input  logic [HI_W-1:0] d,
    output logic [HI_W-1:0] q
);
    // Capture the upper address on load, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (load_en) q <= d;
    end

    // R3: the held bits move only on a load edge
    p_upper_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> q == $past(q));
endmodule

// File: rtl/burst_beat_ctr.sv
// Module: burst_beat_ctr
// Stores the starting low bits of a burst and a wrapping beat count.
// Assumes: load has priority over step; the counter wraps modulo 2**BEAT_W.
module burst_beat_ctr #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              step_en,
    input  logic [BEAT_W-1:0] base_d,
    output logic [BEAT_W-1:0] base_q,
    output logic [BEAT_W-1:0] beat_q
);
    localparam logic [BEAT_W-1:0] BEAT_ONE = BEAT_W'(1);

    // Latch the start bits on load; they stay fixed during the burst.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (load_en) base_q <= base_d;
    end

    // Restart the beat count on load, otherwise step it when asked.
    always_ff @(posedge clk) begin
        if (!rst_n)       beat_q <= '0;
        else if (load_en) beat_q <= '0;
        else if (step_en) beat_q <= beat_q + BEAT_ONE;
    end

    // R7: with no load and no step the count holds
    p_beat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !step_en) |=> $stable(beat_q));
    // R8: a load restarts the count even when a step is requested
    p_load_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && step_en) |=> beat_q == '0);
endmodule

// File: rtl/burst_order_map.sv
// Module: burst_order_map
// Maps the start bits and beat count to the current low address bits.
// Assumes: purely combinational; order may change only while idle.
module burst_order_map
    import burst_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  burst_order_e      order,
    input  logic [BEAT_W-1:0] base,
    input  logic [BEAT_W-1:0] beat,
    output logic [BEAT_W-1:0] low
);
    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] ilv_low;

    // Linear order: modular sum, the carry out of the top bit is dropped.
    always_comb lin_low = base + beat;

    // Interleaved order: one XOR per address bit.
    genvar gi;
    generate
        for (gi = 0; gi < BEAT_W; gi++) begin : g_ilv
            assign ilv_low[gi] = base[gi] ^ beat[gi];
        end
    endgenerate

    // Pick the active order.
    always_comb low = (order == ORD_INTERLEAVE) ? ilv_low : lin_low;
endmodule

// File: rtl/burst_seq_gen.sv
// Module: burst_seq_gen (top)
// Burst address sequence generator: captures a start address on an active-low
// load strobe and steps the low BEAT_W bits on an active-low advance strobe,
// in linear or interleaved order chosen by a static mode input.
// Assumes: mode is static during a burst; synchronous active-low reset.
module burst_seq_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              adv_n,
    input  logic              mode,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] word_addr
);
    localparam int HI_W = ADDR_W - BEAT_W;
    localparam logic [BEAT_W-1:0] STEP_ONE = BEAT_W'(1);

    logic              load_en;
    logic              step_en;
    burst_order_e      order;
    logic [HI_W-1:0]   upper_q;
    logic [BEAT_W-1:0] base_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] low_bits;

    // Decode the active-low strobes and the order strap.
    always_comb begin
        load_en = !load_n;
        step_en = !adv_n;
        order   = burst_order_e'(mode);
    end

    burst_upper_reg #(.HI_W(HI_W)) u_upper (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .d       (start_addr[ADDR_W-1:BEAT_W]),
        .q       (upper_q)
    );

    burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .step_en (step_en),
        .base_d  (start_addr[BEAT_W-1:0]),
        .base_q  (base_q),
        .beat_q  (beat_q)
    );

    burst_order_map #(.BEAT_W(BEAT_W)) u_map (
        .order (order),
        .base  (base_q),
        .beat  (beat_q),
        .low   (low_bits)
    );

    // Assemble the output word.
    always_comb word_addr = {upper_q, low_bits};

    // R1: reset clears the output on the following cycle
    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> word_addr == '0);
    // R2: a load shows the full start address next cycle
    p_load_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> word_addr == $past(start_addr));
    // R4: linear step adds one modulo the block size
    p_linear_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !adv_n && !mode) |=>
        (mode || word_addr[BEAT_W-1:0] == $past(word_addr[BEAT_W-1:0]) + STEP_ONE));
    // R5: stepping never disturbs the upper bits
    p_no_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !adv_n) |=>
        word_addr[ADDR_W-1:BEAT_W] == $past(word_addr[ADDR_W-1:BEAT_W]));
    // R6: interleaved step flips exactly the bits that the beat count flips
    p_ilv_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !adv_n && mode) |=>
        (!mode || (word_addr[BEAT_W-1:0] ^ $past(word_addr[BEAT_W-1:0])) ==
                  ($past(beat_q) ^ ($past(beat_q) + STEP_ONE))));
endmodule

// File: tb/sim_burst_seq_gen.sv
// Bench for burst_seq_gen: a vector table walked by one loop, then directed
// checks for reset behaviour.
module sim_burst_seq_gen;
    localparam int AW = 18;
    localparam int NV = 17;
    // Vector fields: req[4], load_n, adv_n, mode, start[18], expected[18]
    localparam int VW = 4 + 3 + 2 * AW;

    localparam logic [VW-1:0] VEC [NV] = '{
        {4'd2, 1'b0, 1'b1, 1'b0, 18'h12341, 18'h12341}, // R2 load, start low 1
        {4'd4, 1'b1, 1'b0, 1'b0, 18'h00000, 18'h12342}, // R4 linear 1->2
        {4'd4, 1'b1, 1'b0, 1'b0, 18'h00000, 18'h12343}, // R4 linear 2->3
        {4'd7, 1'b1, 1'b1, 1'b0, 18'h3FFFF, 18'h12343}, // R7 idle, start ignored
        {4'd5, 1'b1, 1'b0, 1'b0, 18'h00000, 18'h12340}, // R5 wrap 3->0
        {4'd9, 1'b1, 1'b0, 1'b0, 18'h00000, 18'h12341}, // R9 back to start
        {4'd2, 1'b0, 1'b1, 1'b1, 18'h2ABC1, 18'h2ABC1}, // R2 load interleaved
        {4'd6, 1'b1, 1'b0, 1'b1, 18'h00000, 18'h2ABC0}, // R6 1^1
        {4'd6, 1'b1, 1'b0, 1'b1, 18'h00000, 18'h2ABC3}, // R6 1^2
        {4'd8, 1'b0, 1'b0, 1'b1, 18'h15553, 18'h15553}, // R8 load beats advance
        {4'd6, 1'b1, 1'b0, 1'b1, 18'h00000, 18'h15552}, // R6 3^1 (count restarted)
        {4'd7, 1'b1, 1'b1, 1'b1, 18'h2AAAA, 18'h15552}, // R7 idle interleaved
        {4'd6, 1'b1, 1'b0, 1'b1, 18'h00000, 18'h15551}, // R6 3^2
        {4'd6, 1'b1, 1'b0, 1'b1, 18'h00000, 18'h15550}, // R6 3^3
        {4'd9, 1'b1, 1'b0, 1'b1, 18'h00000, 18'h15553}, // R9 back to start
        {4'd2, 1'b0, 1'b1, 1'b0, 18'h3FFFF, 18'h3FFFF}, // R2 all ones
        {4'd5, 1'b1, 1'b0, 1'b0, 18'h00000, 18'h3FFFC}  // R5 no carry upward
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          mode = 1'b1;
    logic [AW-1:0] start_addr = '0;
    logic [AW-1:0] word_addr;
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    burst_seq_gen #(.ADDR_W(AW), .BEAT_W(2)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_n     (load_n),
        .adv_n      (adv_n),
        .mode       (mode),
        .start_addr (start_addr),
        .word_addr  (word_addr)
    );

    task automatic check(input int req, input logic [AW-1:0] exp);
        checks++;
        if (word_addr !== exp) begin
            errors++;
            $display("FAIL R%0d: word_addr=%05h expected=%05h", req, word_addr, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, sample at the next fall.
    task automatic step(input logic ld, input logic av, input logic md,
                        input logic [AW-1:0] sa);
        load_n = ld; adv_n = av; mode = md; start_addr = sa;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        // R1: reset with a load requested still yields zero
        step(1'b0, 1'b1, 1'b0, 18'h2F0F3);
        step(1'b0, 1'b0, 1'b0, 18'h2F0F3);
        check(1, 18'h00000);
        rst_n = 1'b1;
        step(1'b1, 1'b1, 1'b0, 18'h3FFFF);
        check(1, 18'h00000); // R1 state kept after release, idle edge
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][VW-5], VEC[i][VW-6], VEC[i][VW-7],
                 VEC[i][2*AW-1:AW]);
            check(int'(VEC[i][VW-1:VW-4]), VEC[i][AW-1:0]);
        end
        // R1: mid-run reset overrides a simultaneous load
        rst_n = 1'b0;
        step(1'b0, 1'b0, 1'b1, 18'h11111);
        check(1, 18'h00000);
        rst_n = 1'b1;
        // R6: interleaved start 2 after reset gives 2 then 3
        step(1'b0, 1'b1, 1'b1, 18'h00A02);
        check(6, 18'h00A02);
        step(1'b1, 1'b0, 1'b1, 18'h00000);
        check(6, 18'h00A03);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule